// File: doc/BRIEF.md
# Serial Comma Sequence Detector

This block watches a one-bit serial line and takes in one bit on each clock edge. It raises a sync flag when it has seen a ten-bit comma. A comma is a run of two zeros, then a run of five ones, then three tail bits that may take any value. The bit received first is the first zero of the run. Receivers use the flag to find the point in an unframed bit stream where symbol boundaries start. Alignment and decoding are left to the logic downstream.

Internally the detector is a chain of eleven states, S0 to S10. Each state counts how much of the comma has been matched. The states are stored as a compact four-bit binary index, with Sn held as the value n. The flag is a Moore output decoded from the final state. When a bit does not match, the machine falls back to the longest part of the comma that is still valid. After a detection, the search starts over from the very next bit, so two reported commas never share bits. The run lengths are parameters. The state store can be built either as a binary register or as a one-hot register.

Top module: `comma_seq_detector`

## Requirements
- R1: Reset is synchronous and active-high. The clock edge that samples reset high forces comma_detect to 0 and discards any partial match. Bits taken in before that edge can never complete a comma.
- R2: The bit sequence 0,0,1,1,1,1,1,t,t,t, taken in first bit first, drives comma_detect to 1. The flag is high in the cycle that follows the clock edge that took in the tenth bit.
- R3: All eight values of the three tail bits give a detection.
- R4: Extra zeros before the run of five ones do not prevent a detection. The last two zeros count as the start of the comma.
- R5: A 0 that arrives while the ones are still being counted, with fewer than five ones seen, is kept as a one-zero prefix. One further 0 followed by the rest of the comma then gives a detection.
- R6: A 1 that arrives before two zeros have been seen discards the partial match.
- R7: After a detection, the search starts over from the next bit. A 0 counts as the first zero of a new comma, and a 1 leaves the machine idle. Bits that belong to a reported comma, including its tail bits, never begin another comma.
- R8: comma_detect is 1 for exactly one cycle per detection and 0 otherwise. On any stream it equals a left-to-right, non-overlapping search over windows of ten bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit is taken in per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| comma_detect | output | 1 | Sync flag, 1 in the cycle after a complete comma |

## Verification
The final state does two jobs in the same cycle. It reports the comma just finished, and it takes the first bit of the next search. The bench provokes this by sending commas back to back, with and without a separating bit. It also sends a comma whose tail bits form the start of a second comma. A reference model of the non-overlapping search judges each case bit by bit, so a restart that goes to the wrong state shows up as a missed or extra pulse. The same collision happens between reset and a pending detection. The bench asserts reset while the flag is high, and also just before the tenth bit, and checks that the flag drops and that no late pulse appears.

// File: rtl/comma_det_pkg.sv
package comma_det_pkg;

   // Storage variant for the state chain.
   typedef enum logic {
      ENC_BINARY = 1'b0,
      ENC_ONEHOT = 1'b1
   } state_enc_e;

   // Number of bits needed to hold state indices 0..last.
   function automatic int idx_width(input int last);
      int w;
      w = 1;
      while ((1 << w) <= last) w++;
      return w;
   endfunction

endpackage

// File: rtl/comma_next_state.sv
module comma_next_state #(
   parameter int ZERO_RUN = 2,
   parameter int ONE_RUN  = 5,
   parameter int TAIL_LEN = 3,
   parameter int LAST     = ZERO_RUN + ONE_RUN + TAIL_LEN,
   parameter int IDX_W    = comma_det_pkg::idx_width(LAST)
) (
   input  logic [IDX_W-1:0] cur_idx,
   input  logic             cur_valid,
   input  logic             bit_in,
   output logic [IDX_W-1:0] nxt_idx
);

   localparam int ONES_DONE = ZERO_RUN + ONE_RUN;

   localparam logic [IDX_W-1:0] IDLE_C   = '0;
   localparam logic [IDX_W-1:0] ONE_Z_C  = IDX_W'(1);
   localparam logic [IDX_W-1:0] ZFULL_C  = IDX_W'(ZERO_RUN);
   localparam logic [IDX_W-1:0] FIRST1_C = IDX_W'(ZERO_RUN + 1);
   localparam logic [IDX_W-1:0] ODONE_C  = IDX_W'(ONES_DONE);
   localparam logic [IDX_W-1:0] LAST_C   = IDX_W'(LAST);

   generate
      if (ZERO_RUN < 1) begin : g_bad_zero
         $error("comma_next_state: ZERO_RUN must be at least 1");
      end
      if (ONE_RUN < 1) begin : g_bad_one
         $error("comma_next_state: ONE_RUN must be at least 1");
      end
      if (TAIL_LEN < 0) begin : g_bad_tail
         $error("comma_next_state: TAIL_LEN must not be negative");
      end
      if (LAST != ZERO_RUN + ONE_RUN + TAIL_LEN) begin : g_bad_last
         $error("comma_next_state: LAST does not match the run lengths");
      end
   endgenerate

   always_comb begin
      if (!cur_valid) begin
         // unused code: recover to idle
         nxt_idx = IDLE_C;
      end else if (cur_idx == LAST_C) begin
         // comma reported: restart from this bit
         nxt_idx = bit_in ? IDLE_C : ONE_Z_C;
      end else if (cur_idx < ZFULL_C) begin
         // collecting zeros
         nxt_idx = bit_in ? IDLE_C : (cur_idx + ONE_Z_C);
      end else if (cur_idx == ZFULL_C) begin
         // zero run complete: more zeros keep the suffix
         nxt_idx = bit_in ? FIRST1_C : ZFULL_C;
      end else if (cur_idx < ODONE_C) begin
         // counting ones: a zero leaves a one-zero prefix
         nxt_idx = bit_in ? (cur_idx + ONE_Z_C) : ONE_Z_C;
      end else begin
         // tail positions accept any value
         nxt_idx = cur_idx + ONE_Z_C;
      end
   end

endmodule

// File: rtl/comma_state_store.sv
module comma_state_store #(
   parameter comma_det_pkg::state_enc_e ENCODING = comma_det_pkg::ENC_BINARY,
   parameter int LAST  = 10,
   parameter int IDX_W = comma_det_pkg::idx_width(LAST)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] nxt_idx,
   output logic [IDX_W-1:0] cur_idx,
   output logic             cur_valid
);

   localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LAST);

   generate
      if ((1 << IDX_W) <= LAST) begin : g_bad_width
         $error("comma_state_store: IDX_W too narrow for LAST");
      end

      if (ENCODING == comma_det_pkg::ENC_BINARY) begin : g_binary
         logic [IDX_W-1:0] code_q;

         always_ff @(posedge clk) begin
            if (rst) code_q <= '0;
            else     code_q <= nxt_idx;
         end

         assign cur_idx   = code_q;
         assign cur_valid = (code_q <= LAST_C);

      end else begin : g_onehot
         logic [LAST:0] hot_q;
         logic [LAST:0] hot_d;
         logic [IDX_W-1:0] enc_idx;

         always_comb begin
            hot_d = '0;
            for (int i = 0; i <= LAST; i++) begin
               if (nxt_idx == IDX_W'(i)) hot_d[i] = 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (rst) hot_q <= (LAST+1)'(1);
            else     hot_q <= hot_d;
         end

         always_comb begin
            enc_idx = '0;
            for (int i = 0; i <= LAST; i++) begin
               if (hot_q[i]) enc_idx = enc_idx | IDX_W'(i);
            end
         end

         assign cur_idx   = enc_idx;
         assign cur_valid = $onehot(hot_q);
      end
   endgenerate

   // The stored state must always be a legal code once out of reset.
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      cur_valid && (cur_idx <= LAST_C)); // R8

endmodule

// File: rtl/comma_flag_decode.sv
module comma_flag_decode #(
   parameter int LAST  = 10,
   parameter int IDX_W = comma_det_pkg::idx_width(LAST)
) (
   input  logic [IDX_W-1:0] cur_idx,
   input  logic             cur_valid,
   output logic             flag
);

   localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LAST);

   // Moore output: one state value only
   assign flag = cur_valid && (cur_idx == LAST_C);

endmodule

// File: rtl/comma_seq_detector.sv
module comma_seq_detector #(
   parameter int ZERO_RUN = 2,
   parameter int ONE_RUN  = 5,
   parameter int TAIL_LEN = 3,
   parameter comma_det_pkg::state_enc_e ENCODING = comma_det_pkg::ENC_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic comma_detect
);

   localparam int LAST      = ZERO_RUN + ONE_RUN + TAIL_LEN;
   localparam int ONES_DONE = ZERO_RUN + ONE_RUN;
   localparam int IDX_W     = comma_det_pkg::idx_width(LAST);

   localparam logic [IDX_W-1:0] IDLE_C   = '0;
   localparam logic [IDX_W-1:0] ONE_Z_C  = IDX_W'(1);
   localparam logic [IDX_W-1:0] ZFULL_C  = IDX_W'(ZERO_RUN);
   localparam logic [IDX_W-1:0] ODONE_C  = IDX_W'(ONES_DONE);
   localparam logic [IDX_W-1:0] LAST_C   = IDX_W'(LAST);
   localparam logic [IDX_W-1:0] PRE_C    = IDX_W'(LAST - 1);

   generate
      if (LAST < 2) begin : g_bad_len
         $error("comma_seq_detector: comma must be at least two bits");
      end
   endgenerate

   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] nxt_idx;
   logic             cur_valid;

   comma_next_state #(
      .ZERO_RUN (ZERO_RUN),
      .ONE_RUN  (ONE_RUN),
      .TAIL_LEN (TAIL_LEN),
      .LAST     (LAST),
      .IDX_W    (IDX_W)
   ) u_next (
      .cur_idx   (cur_idx),
      .cur_valid (cur_valid),
      .bit_in    (bit_in),
      .nxt_idx   (nxt_idx)
   );

   comma_state_store #(
      .ENCODING (ENCODING),
      .LAST     (LAST),
      .IDX_W    (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .nxt_idx   (nxt_idx),
      .cur_idx   (cur_idx),
      .cur_valid (cur_valid)
   );

   comma_flag_decode #(
      .LAST  (LAST),
      .IDX_W (IDX_W)
   ) u_dec (
      .cur_idx   (cur_idx),
      .cur_valid (cur_valid),
      .flag      (comma_detect)
   );

   // Reset edge clears the flag and the match.
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!comma_detect && (cur_idx == IDLE_C))); // R1

   // A detection is always preceded by the last tail position.
   AST_DETECT_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
      comma_detect |-> ($past(cur_idx) == PRE_C)); // R2

   // Extra zeros hold the full zero run.
   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((cur_idx == ZFULL_C) && !bit_in) |=> (cur_idx == ZFULL_C)); // R4

   // A zero inside the ones run leaves a one-zero prefix.
   AST_ZERO_IN_ONES: assert property (@(posedge clk) disable iff (rst)
      ((cur_idx > ZFULL_C) && (cur_idx < ODONE_C) && !bit_in)
      |=> (cur_idx == ONE_Z_C)); // R5

   // A one before the zero run completes drops to idle.
   AST_EARLY_ONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      ((cur_idx < ZFULL_C) && bit_in) |=> (cur_idx == IDLE_C)); // R6

   // After a detection the next bit restarts the search.
   AST_RESTART: assert property (@(posedge clk) disable iff (rst)
      (cur_idx == LAST_C) |=> (cur_idx == ($past(bit_in) ? IDLE_C : ONE_Z_C))); // R7

   // The flag never stays high for two cycles.
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      comma_detect |=> !comma_detect); // R8

endmodule

// File: tb/tb_comma_seq_detector.sv
module tb_comma_seq_detector;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic comma_detect;

   always #(CLK_PERIOD/2) clk = ~clk;

   comma_seq_detector dut (
      .clk          (clk),
      .rst          (rst),
      .bit_in       (bit_in),
      .comma_detect (comma_detect)
   );

   // Vector table: bits sent MSB first over LEN bits, expected first
   // detection position (1-based, 0 = none) and detection count.
   localparam logic [31:0] V_BITS [NV] = '{
      32'b0011111010,             // R2 basic comma
      32'b0011111111,             // R3 tail all ones
      32'b0011111000,             // R3 tail all zeros
      32'b000011111101,           // R4 extra leading zeros
      32'b00110011111011,         // R5 zero inside ones, then recovery
      32'b0011101111100,          // R5 zero inside ones, no recovery
      32'b010011111001,           // R6 early one then comma
      32'b01011111000,            // R6 early ones, no comma
      32'b001111100011111000,     // R7 tail starts a comma: not reported
      32'b00111111110011111101,   // R7 zero after detection restarts
      32'b001111111110011111000   // R7 one after detection idles
   };
   localparam int V_LEN [NV] = '{10, 10, 10, 12, 14, 13, 12, 11, 18, 20, 21};
   localparam int V_POS [NV] = '{10, 10, 10, 12, 14, 0, 12, 0, 10, 10, 10};
   localparam int V_CNT [NV] = '{1, 1, 1, 1, 1, 0, 1, 0, 1, 2, 2};
   localparam int V_REQ [NV] = '{2, 3, 3, 4, 5, 5, 6, 6, 7, 7, 7};

   int checks = 0;
   int errors = 0;

   // Reference: non-overlapping search over ten-bit windows.
   logic [9:0] hist;
   int nbits;
   int gap;
   logic ref_det;

   task automatic ref_clear();
      hist = '0;
      nbits = 0;
      gap = 1000;
      ref_det = 1'b0;
   endtask

   task automatic ref_step(input logic b);
      hist = {hist[8:0], b};
      nbits++;
      gap++;
      ref_det = (nbits >= 10) && (hist[9:8] == 2'b00) &&
                (hist[7:3] == 5'b11111) && (gap >= 10);
      if (ref_det) gap = 0;
   endtask

   task automatic check(input int req, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic check_int(input int req, input string what,
                            input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst = 1'b1;
      bit_in = 1'b0;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(1, "flag after reset edge", comma_detect, 1'b0); // R1
      @(negedge clk);
      rst = 1'b0;
      ref_clear();
   endtask

   // Send one bit, sample after the edge, compare with the reference.
   task automatic send_bit(input logic b, input int req, output logic got);
      @(negedge clk);
      bit_in = b;
      @(posedge clk);
      #(CLK_PERIOD/4);
      ref_step(b);
      got = comma_detect;
      check(req, "per-bit flag", got, ref_det);
   endtask

   task automatic send_comma(input logic [2:0] tail, input int req);
      logic got;
      logic [9:0] w;
      w = {7'b0011111, tail};
      for (int k = 9; k >= 0; k--) send_bit(w[k], req, got);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic got;
      int first_pos;
      int det_cnt;

      ref_clear();
      repeat (2) @(posedge clk);
      #(CLK_PERIOD/4);
      check(1, "flag during reset", comma_detect, 1'b0); // R1
      @(negedge clk);
      rst = 1'b0;

      // Table walk
      for (int v = 0; v < NV; v++) begin
         pulse_reset();
         first_pos = 0;
         det_cnt = 0;
         for (int k = V_LEN[v] - 1; k >= 0; k--) begin
            send_bit(V_BITS[v][k], V_REQ[v], got);
            if (got === 1'b1) begin
               det_cnt++;
               if (first_pos == 0) first_pos = V_LEN[v] - k;
            end
         end
         check_int(V_REQ[v], "first detection position", first_pos, V_POS[v]);
         check_int(V_REQ[v], "detection count", det_cnt, V_CNT[v]);
         // flag must fall after the pulse
         send_bit(1'b1, 8, got); // R8
      end

      // R3: every tail value detects
      for (int t = 0; t < 8; t++) begin
         pulse_reset();
         send_comma(3'(t), 3);
         check(3, "tail value detect", comma_detect, 1'b1);
      end

      // R1: reset in the middle discards the partial match
      pulse_reset();
      for (int k = 0; k < 7; k++) send_bit((k >= 2), 1, got);
      pulse_reset();
      send_bit(1'b0, 1, got);
      send_bit(1'b1, 1, got);
      send_bit(1'b0, 1, got);
      check(1, "no detect after mid reset", comma_detect, 1'b0);

      // R1: reset one bit before completion
      pulse_reset();
      for (int k = 0; k < 9; k++) send_bit((k >= 2 && k < 7), 1, got);
      pulse_reset();
      send_bit(1'b1, 1, got);
      check(1, "no late pulse after reset", comma_detect, 1'b0);

      // R1: reset while flag high
      pulse_reset();
      send_comma(3'b101, 2);
      check(2, "flag high before reset", comma_detect, 1'b1);
      pulse_reset();

      // R7: back-to-back commas with no gap
      pulse_reset();
      send_comma(3'b110, 7);
      send_comma(3'b011, 7);
      check(7, "back-to-back second comma", comma_detect, 1'b1);

      // R8: long random stream with embedded commas
      pulse_reset();
      det_cnt = 0;
      for (int n = 0; n < 3000; n++) begin
         if (($urandom % 16) == 0) begin
            send_comma(3'($urandom), 8);
            det_cnt++;
         end else begin
            send_bit(1'($urandom), 8, got);
         end
      end
      check(8, "random stream held commas", (det_cnt > 0), 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule